// File: doc/BRIEF.md
# PCI Configuration Window Address Translator

This block sits between a simple CPU bus and a configuration-space port. It serves two ways of reaching configuration registers. The first is a 4 MB memory-mapped window at CPU address 0x8080_0000. There the target device is named by a one-hot address bit: the lowest set bit among address bits 21..11 gives the device number. The second is the usual indirect pair in I/O space: an index register at I/O 0xCF8 and a data port at I/O 0xCFC, both 4 bytes wide and little-endian.

Each CPU access is a single-cycle strobe. The access carries a byte size and a byte offset, and the block answers it with a one-cycle done pulse. An access that needs a target raises a configuration request. The request holds its address, byte enables and write data until the target acknowledges or a fixed timeout expires. Reads are then returned right-justified.

Top module: `cfgwin_xlate`

## Requirements
- R1: A memory-space access (cpu_io=0) with address in 0x8080_0000..0x80BF_FFFF raises a configuration request on bus 0. Any other memory-space address raises none.
- R2: In the window, the device number is the index of the lowest set bit among address bits 21..11, counted so that bit 11 gives 0. When none of these bits is set, the device number is 11.
- R3: cfg_addr is {bus[23:16], device[15:11], function[10:8], register[7:2], 2'b00}. In the window, the function is address bits 10:8 and the register is address bits 7:2.
- R4: cpu_size 0, 1 and 2 (or 3) select 1, 2 and 4 bytes. cfg_be is the size mask shifted left by addr[1:0]. Write byte 0 travels on lane addr[1:0]. Read data is shifted right by addr[1:0] bytes, and bytes beyond the size read as zero.
- R5: The index register is reached with I/O addresses 0xCF8..0xCFB, with per-byte writes and aligned reads. Bits 30:24 and 1:0 always read as zero.
- R6: A data-port access (I/O 0xCFC..0xCFF) while index bit 31 is set raises a request. Bus, device, function and register come from index bits 23:16, 15:11, 10:8 and 7:2, and the byte offset comes from addr[1:0].
- R7: A data-port access while index bit 31 is clear raises no request. Done follows one cycle after the strobe. A write has no effect, and a read returns ones in the bytes of the access width.
- R8: A request that is not acknowledged within TMO_CYCLES cycles is dropped and the access completes. A read then returns ones in the bytes of the access width.
- R9: The request holds cfg_addr, cfg_be, cfg_we and cfg_wdata stable until it ends. Done rises in the cycle after the acknowledge edge, and cfg_req falls in that same cycle.
- R10: I/O accesses to any other address, and memory accesses outside the window, complete one cycle after the strobe without a request. Reads return ones in the access width.
- R11: After reset, cfg_req and cpu_done are low and the index register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | One-cycle access strobe, taken only when idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_io | input | 1 | 1 = I/O space, 0 = memory space |
| cpu_addr | input | 32 | Byte address |
| cpu_size | input | 2 | Access size code |
| cpu_wdata | input | 32 | Right-justified write value |
| cpu_done | output | 1 | Access complete pulse |
| cpu_rdata | output | 32 | Right-justified read value, valid with cpu_done |
| cfg_req | output | 1 | Configuration request |
| cfg_we | output | 1 | Request is a write |
| cfg_addr | output | 24 | Bus, device, function, dword register |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Write data on byte lanes |
| cfg_ack | input | 1 | Target acknowledge |
| cfg_rdata | input | 32 | Target read data on byte lanes, valid with cfg_ack |

## Verification
An access that only touches the index register, the disabled data port or an unmapped address finishes on the first cycle after its strobe. The request fields of a mapped access appear on that same first cycle. Done follows one cycle after the acknowledge edge, so with a responder that acknowledges on its second cycle the done pulse arrives three cycles after the strobe. A timed-out access ends TMO_CYCLES+1 cycles after the strobe. The bench drives inputs and samples outputs only on falling edges. It counts those edges from the strobe to done and compares the count with these figures, along with the captured request fields and the returned data.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  localparam int LANES   = 4;
  localparam int SCAN_LO = 11;
  localparam int DEV_W   = 5;
  localparam logic [31:0] IDX_KEEP = 32'h80FF_FFFC;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_WIN  = 2'd1,
    TGT_IDX  = 2'd2,
    TGT_DATA = 2'd3
  } cw_tgt_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } cw_state_e;

  typedef struct packed {
    logic [7:0]       bus;
    logic [DEV_W-1:0] dev;
    logic [2:0]       fn;
    logic [7:0]       ofs;
  } cw_cfga_t;

  function automatic logic [LANES-1:0] size_mask(input logic [1:0] sz);
    logic [LANES-1:0] m;
    unique case (sz)
      2'd0:    m = 4'b0001;
      2'd1:    m = 4'b0011;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/cfgwin_decode.sv
module cfgwin_decode
  import cfgwin_pkg::*;
#(
  parameter logic [31:0] WIN_BASE = 32'h8080_0000,
  parameter int          WIN_LOG2 = 22,
  parameter int          SCAN_N   = 11,
  parameter logic [15:0] IO_IDX   = 16'h0CF8,
  parameter logic [15:0] IO_DAT   = 16'h0CFC
) (
  input  logic [31:0] addr,
  input  logic        io,
  input  logic [21:0] idx_f,
  output cw_tgt_e     tgt,
  output cw_cfga_t    cfga
);

  localparam int SEL_W = $clog2(SCAN_N + 1);

  logic [SCAN_N-1:0] seen;
  logic [SCAN_N-1:0] first;
  logic [SEL_W-1:0]  sel;
  logic              win_hit;
  logic              idx_hit;
  logic              dat_hit;

  // priority chain: first[i] marks the lowest set scan bit
  genvar gi;
  generate
    for (gi = 0; gi < SCAN_N; gi++) begin : g_scan
      if (gi == 0) begin : g_head
        assign first[gi] = addr[SCAN_LO + gi];
        assign seen[gi]  = addr[SCAN_LO + gi];
      end else begin : g_tail
        assign first[gi] = addr[SCAN_LO + gi] & ~seen[gi-1];
        assign seen[gi]  = addr[SCAN_LO + gi] | seen[gi-1];
      end
    end
  endgenerate

  always_comb begin
    sel = SEL_W'(SCAN_N);
    if (seen[SCAN_N-1]) begin
      sel = '0;
      for (int i = 0; i < SCAN_N; i++) begin
        if (first[i]) sel = sel | SEL_W'(i);
      end
    end
  end

  assign win_hit = !io && (addr[31:WIN_LOG2] == WIN_BASE[31:WIN_LOG2]);
  assign idx_hit = io && (addr[15:2] == IO_IDX[15:2]);
  assign dat_hit = io && (addr[15:2] == IO_DAT[15:2]);

  always_comb begin
    if (win_hit)      tgt = TGT_WIN;
    else if (idx_hit) tgt = TGT_IDX;
    else if (dat_hit) tgt = TGT_DATA;
    else              tgt = TGT_NONE;
  end

  always_comb begin
    if (dat_hit) begin
      cfga.bus = idx_f[21:14];
      cfga.dev = idx_f[13:9];
      cfga.fn  = idx_f[8:6];
      cfga.ofs = {idx_f[5:0], 2'b00};
    end else begin
      cfga.bus = 8'h00;
      cfga.dev = DEV_W'(sel);
      cfga.fn  = addr[10:8];
      cfga.ofs = {addr[7:2], 2'b00};
    end
  end

endmodule

// File: rtl/cfgwin_lanes.sv
module cfgwin_lanes
  import cfgwin_pkg::*;
(
  input  logic [1:0]       w_size,
  input  logic [1:0]       w_off,
  input  logic [31:0]      w_data,
  output logic [LANES-1:0] w_be,
  output logic [31:0]      w_lane,
  input  logic [1:0]       r_size,
  input  logic [1:0]       r_off,
  input  logic [31:0]      r_lane,
  output logic [31:0]      r_val,
  output logic [31:0]      r_ones
);

  logic [LANES-1:0] wmask;
  logic [LANES-1:0] rmask;

  assign wmask  = size_mask(w_size);
  assign rmask  = size_mask(r_size);
  assign w_be   = wmask << w_off;
  assign w_lane = w_data << {w_off, 3'b000};

  genvar gb;
  generate
    for (gb = 0; gb < LANES; gb++) begin : g_ones
      assign r_ones[8*gb +: 8] = {8{rmask[gb]}};
    end
  endgenerate

  assign r_val = (r_lane >> {r_off, 3'b000}) & r_ones;

endmodule

// File: rtl/cfgwin_ctrl.sv
module cfgwin_ctrl
  import cfgwin_pkg::*;
#(
  parameter int TMO_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [1:0]       cpu_size,
  input  logic [1:0]       cpu_off,
  input  cw_tgt_e          tgt,
  input  cw_cfga_t         cfga_in,
  input  logic [LANES-1:0] be_in,
  input  logic [31:0]      wlane_in,
  input  logic [31:0]      al_val,
  input  logic [31:0]      al_ones,
  input  logic             cfg_ack,
  output logic [31:0]      idx_q,
  output logic             wait_o,
  output logic [1:0]       size_q,
  output logic [1:0]       off_q,
  output logic             done_q,
  output logic [31:0]      rdata_q,
  output logic             req_q,
  output logic             we_q,
  output cw_cfga_t         cfga_q,
  output logic [LANES-1:0] be_q,
  output logic [31:0]      wd_q
);

  localparam int CNT_W = $clog2(TMO_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYCLES - 1);

  cw_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_d, done_d;
  logic [31:0]      rdata_d;
  logic [31:0]      idx_new;
  logic             ld_cmd, idx_en, go_cfg;

  assign wait_o = (st_q == ST_WAIT);
  assign go_cfg = (tgt == TGT_WIN) || ((tgt == TGT_DATA) && idx_q[31]);

  always_comb begin
    idx_new = idx_q;
    for (int b = 0; b < LANES; b++) begin
      if (be_in[b]) idx_new[8*b +: 8] = wlane_in[8*b +: 8];
    end
    idx_new = idx_new & IDX_KEEP;
  end

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    req_d   = req_q;
    done_d  = 1'b0;
    rdata_d = rdata_q;
    ld_cmd  = 1'b0;
    idx_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cpu_req) begin
          if (go_cfg) begin
            ld_cmd = 1'b1;
            req_d  = 1'b1;
            cnt_d  = '0;
            st_d   = ST_WAIT;
          end else begin
            done_d = 1'b1;
            if (cpu_we) begin
              rdata_d = '0;
              idx_en  = (tgt == TGT_IDX);
            end else begin
              rdata_d = (tgt == TGT_IDX) ? al_val : al_ones;
            end
          end
        end
      end
      ST_WAIT: begin
        if (cfg_ack || (cnt_q == CNT_LAST)) begin
          req_d   = 1'b0;
          done_d  = 1'b1;
          st_d    = ST_IDLE;
          rdata_d = we_q ? 32'h0 : (cfg_ack ? al_val : al_ones);
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
      idx_q   <= '0;
      we_q    <= 1'b0;
      cfga_q  <= '0;
      be_q    <= '0;
      wd_q    <= '0;
      size_q  <= '0;
      off_q   <= '0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      req_q   <= req_d;
      done_q  <= done_d;
      rdata_q <= rdata_d;
      if (idx_en) idx_q <= idx_new;
      if (ld_cmd) begin
        we_q   <= cpu_we;
        cfga_q <= cfga_in;
        be_q   <= be_in;
        wd_q   <= wlane_in;
        size_q <= cpu_size;
        off_q  <= cpu_off;
      end
    end
  end

endmodule

// File: rtl/cfgwin_xlate.sv
module cfgwin_xlate
  import cfgwin_pkg::*;
#(
  parameter logic [31:0] WIN_BASE   = 32'h8080_0000,
  parameter int          WIN_LOG2   = 22,
  parameter int          SCAN_N     = 11,
  parameter logic [15:0] IO_IDX     = 16'h0CF8,
  parameter logic [15:0] IO_DAT     = 16'h0CFC,
  parameter int          TMO_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic        cpu_io,
  input  logic [31:0] cpu_addr,
  input  logic [1:0]  cpu_size,
  input  logic [31:0] cpu_wdata,
  output logic        cpu_done,
  output logic [31:0] cpu_rdata,
  output logic        cfg_req,
  output logic        cfg_we,
  output logic [23:0] cfg_addr,
  output logic [3:0]  cfg_be,
  output logic [31:0] cfg_wdata,
  input  logic        cfg_ack,
  input  logic [31:0] cfg_rdata
);

  logic [1:0]  rs_q;
  logic        rst_ni;
  cw_tgt_e     tgt;
  cw_cfga_t    cfga_dec;
  cw_cfga_t    cfga_q;
  logic [3:0]  be_w;
  logic [31:0] wlane_w;
  logic [31:0] idx_q;
  logic        wait_w;
  logic [1:0]  size_q, off_q;
  logic [1:0]  r_size, r_off;
  logic [31:0] r_lane, al_val, al_ones;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  cfgwin_decode #(
    .WIN_BASE (WIN_BASE),
    .WIN_LOG2 (WIN_LOG2),
    .SCAN_N   (SCAN_N),
    .IO_IDX   (IO_IDX),
    .IO_DAT   (IO_DAT)
  ) u_dec (
    .addr  (cpu_addr),
    .io    (cpu_io),
    .idx_f (idx_q[23:2]),
    .tgt   (tgt),
    .cfga  (cfga_dec)
  );

  assign r_lane = wait_w ? cfg_rdata : idx_q;
  assign r_size = wait_w ? size_q : cpu_size;
  assign r_off  = wait_w ? off_q : cpu_addr[1:0];

  cfgwin_lanes u_lanes (
    .w_size (cpu_size),
    .w_off  (cpu_addr[1:0]),
    .w_data (cpu_wdata),
    .w_be   (be_w),
    .w_lane (wlane_w),
    .r_size (r_size),
    .r_off  (r_off),
    .r_lane (r_lane),
    .r_val  (al_val),
    .r_ones (al_ones)
  );

  cfgwin_ctrl #(
    .TMO_CYCLES (TMO_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_ni),
    .cpu_req  (cpu_req),
    .cpu_we   (cpu_we),
    .cpu_size (cpu_size),
    .cpu_off  (cpu_addr[1:0]),
    .tgt      (tgt),
    .cfga_in  (cfga_dec),
    .be_in    (be_w),
    .wlane_in (wlane_w),
    .al_val   (al_val),
    .al_ones  (al_ones),
    .cfg_ack  (cfg_ack),
    .idx_q    (idx_q),
    .wait_o   (wait_w),
    .size_q   (size_q),
    .off_q    (off_q),
    .done_q   (cpu_done),
    .rdata_q  (cpu_rdata),
    .req_q    (cfg_req),
    .we_q     (cfg_we),
    .cfga_q   (cfga_q),
    .be_q     (cfg_be),
    .wd_q     (cfg_wdata)
  );

  assign cfg_addr = cfga_q;

endmodule

// File: rtl/cfgwin_chk.sv
module cfgwin_chk #(
  parameter int TMO_CYCLES = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_req,
  input logic        cfg_ack,
  input logic [23:0] cfg_addr,
  input logic [3:0]  cfg_be,
  input logic        cfg_we,
  input logic [31:0] cfg_wdata,
  input logic        cpu_done
);

  localparam int CW = $clog2(TMO_CYCLES + 2);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);
  localparam logic [CW-1:0] LIM  = CW'(TMO_CYCLES);

  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_cnt <= '0;
    else if (!cfg_req) hi_cnt <= '0;
    else               hi_cnt <= hi_cnt + 1'b1;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_ack && hi_cnt != LAST) |=> (cfg_req && $stable(cfg_addr) && $stable(cfg_be) && $stable(cfg_we) && $stable(cfg_wdata))); // R9

  AST_ACK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && cfg_ack) |=> (!cfg_req && cpu_done)); // R9

  AST_TMO_END: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_ack && hi_cnt == LAST) |=> (!cfg_req && cpu_done)); // R8

  AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (hi_cnt < LIM)); // R8

  AST_BE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (cfg_be != 4'h0 && cfg_addr[1:0] == 2'b00)); // R4

endmodule

bind cfgwin_xlate cfgwin_chk #(.TMO_CYCLES(TMO_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_req   (cfg_req),
  .cfg_ack   (cfg_ack),
  .cfg_addr  (cfg_addr),
  .cfg_be    (cfg_be),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .cpu_done  (cpu_done)
);

// File: tb/sim_cfgwin_xlate.sv
`timescale 1ns/1ps
module sim_cfgwin_xlate;

  localparam int TMO = 16;
  localparam int ACK_DLY = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we, cpu_io;
  logic [31:0] cpu_addr, cpu_wdata;
  logic [1:0]  cpu_size;
  logic        cpu_done;
  logic [31:0] cpu_rdata;
  logic        cfg_req, cfg_we;
  logic [23:0] cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cfg_ack;
  logic [31:0] cfg_rdata;

  always #2.5 clk = ~clk;

  cfgwin_xlate #(.TMO_CYCLES(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_io(cpu_io),
    .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .cfg_req(cfg_req), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata)
  );

  // target model: word store keyed by device[3:0] and register[7:2]; device 7 on bus 0 never answers
  logic [31:0] tmem [0:1023];
  int          nreq;
  logic [23:0] cap_addr;
  logic [3:0]  cap_be;
  logic        cap_we;
  logic [31:0] cap_wd;

  function automatic logic [9:0] key(input logic [23:0] a);
    return {a[14:11], a[7:2]};
  endfunction

  initial begin
    int rc;
    logic [31:0] w;
    for (int i = 0; i < 1024; i++) begin
      tmem[i] = {8'hA5, 8'(i), 8'h5A ^ {6'b0, 2'(i >> 8)}, ~8'(i)};
    end
    nreq = 0; rc = 0; cfg_ack = 1'b0; cfg_rdata = '0;
    cap_addr = '0; cap_be = '0; cap_we = 1'b0; cap_wd = '0;
    forever begin
      @(negedge clk);
      if (cfg_req) begin
        if (rc == 0) begin
          nreq = nreq + 1;
          cap_addr = cfg_addr; cap_be = cfg_be; cap_we = cfg_we; cap_wd = cfg_wdata;
        end
        rc = rc + 1;
        if (rc == ACK_DLY && !(cfg_addr[23:16] == 8'h00 && cfg_addr[15:11] == 5'd7)) begin
          cfg_ack = 1'b1;
          w = tmem[key(cfg_addr)];
          cfg_rdata = w;
          if (cfg_we) begin
            for (int b = 0; b < 4; b++) if (cfg_be[b]) w[8*b +: 8] = cfg_wdata[8*b +: 8];
            tmem[key(cfg_addr)] = w;
          end
        end else begin
          cfg_ack = 1'b0;
        end
      end else begin
        rc = 0;
        cfg_ack = 1'b0;
      end
    end
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ext(input logic [31:0] w, input logic [1:0] off, input logic [1:0] sz);
    logic [31:0] m;
    m = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    return (w >> (8 * off)) & m;
  endfunction

  logic [31:0] r_data;
  int          r_cyc;
  int          r_nreq;

  task automatic access(input logic io, input logic we, input logic [31:0] a,
                        input logic [1:0] sz, input logic [31:0] wd);
    int n0;
    @(negedge clk);
    n0 = nreq;
    cpu_io = io; cpu_we = we; cpu_addr = a; cpu_size = sz; cpu_wdata = wd; cpu_req = 1'b1;
    @(negedge clk);
    cpu_req = 1'b0;
    r_cyc = 1;
    while (!cpu_done && r_cyc < 200) begin
      @(negedge clk);
      r_cyc++;
    end
    r_data = cpu_rdata;
    r_nreq = nreq - n0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  size;
    logic        req;
    logic [23:0] cfga;
    logic [3:0]  be;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{32'h8080_0800, 2'd2, 1'b1, 24'h000000, 4'hF},
    '{32'h8080_1014, 2'd2, 1'b1, 24'h000814, 4'hF},
    '{32'h80A0_8302, 2'd1, 1'b1, 24'h002300, 4'hC},
    '{32'h80A0_00FF, 2'd0, 1'b1, 24'h0050FC, 4'h8},
    '{32'h8080_0004, 2'd2, 1'b1, 24'h005804, 4'hF},
    '{32'h80BF_F8C1, 2'd0, 1'b1, 24'h0000C0, 4'h2},
    '{32'h8080_27A8, 2'd2, 1'b1, 24'h0017A8, 4'hF},
    '{32'h8090_0203, 2'd0, 1'b1, 24'h004A00, 4'h8},
    '{32'h80C0_0000, 2'd2, 1'b0, 24'h000000, 4'h0},
    '{32'h807F_FFFC, 2'd2, 1'b0, 24'h000000, 4'h0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_io = 1'b0;
    cpu_addr = '0; cpu_size = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11 cfg_req after reset", 32'(cfg_req), 32'd0);
    chk("R11 cpu_done after reset", 32'(cpu_done), 32'd0);
    access(1'b1, 1'b0, 32'h0CF8, 2'd2, 0);
    chk("R11 index after reset", r_data, 32'h0);

    // table walk: window reads (R1 R2 R3 R4 R9 R10)
    for (int i = 0; i < 10; i++) begin
      access(1'b0, 1'b0, VEC[i].addr, VEC[i].size, 0);
      if (VEC[i].req) begin
        chk($sformatf("R1 req count v%0d", i), 32'(r_nreq), 32'd1);
        chk($sformatf("R2/R3 cfg_addr v%0d", i), 32'(cap_addr), 32'(VEC[i].cfga));
        chk($sformatf("R4 cfg_be v%0d", i), 32'(cap_be), 32'(VEC[i].be));
        chk($sformatf("R4 rdata v%0d", i), r_data,
            ext(tmem[key(VEC[i].cfga)], VEC[i].addr[1:0], VEC[i].size));
        chk($sformatf("R9 latency v%0d", i), 32'(r_cyc), 32'(ACK_DLY + 1));
      end else begin
        chk($sformatf("R10 no req v%0d", i), 32'(r_nreq), 32'd0);
        chk($sformatf("R10 rdata v%0d", i), r_data, 32'hFFFF_FFFF);
        chk($sformatf("R10 latency v%0d", i), 32'(r_cyc), 32'd1);
      end
    end

    // R5 index register masking and byte writes
    access(1'b1, 1'b1, 32'h0CF8, 2'd2, 32'hFFFF_FFFF);
    chk("R5 index write latency", 32'(r_cyc), 32'd1);
    access(1'b1, 1'b0, 32'h0CF8, 2'd2, 0);
    chk("R5 index reserved bits", r_data, 32'h80FF_FFFC);
    access(1'b1, 1'b1, 32'h0CF9, 2'd0, 32'h12);
    access(1'b1, 1'b0, 32'h0CF8, 2'd2, 0);
    chk("R5 index byte write", r_data, 32'h80FF_12FC);
    access(1'b1, 1'b0, 32'h0CFA, 2'd1, 0);
    chk("R5 index half read", r_data, 32'h0000_80FF);

    // R6 data port through index
    access(1'b1, 1'b1, 32'h0CF8, 2'd2, 32'h8000_1A10);
    access(1'b1, 1'b0, 32'h0CFE, 2'd1, 0);
    chk("R6 data port addr", 32'(cap_addr), 32'h001A10);
    chk("R6 data port be", 32'(cap_be), 32'hC);
    chk("R6 data port rdata", r_data, ext(tmem[key(24'h001A10)], 2'd2, 2'd1));
    access(1'b1, 1'b1, 32'h0CFC, 2'd2, 32'hDEAD_BEEF);
    chk("R6 data port write we", 32'(cap_we), 32'd1);
    access(1'b0, 1'b0, 32'h8080_4210, 2'd2, 0);
    chk("R6 write seen via window", r_data, 32'hDEAD_BEEF);

    // R4 byte-lane write through window
    access(1'b0, 1'b1, 32'h8080_4211, 2'd0, 32'h77);
    chk("R4 write be", 32'(cap_be), 32'h2);
    chk("R4 write lane", cap_wd & 32'h0000_FF00, 32'h0000_7700);
    access(1'b0, 1'b0, 32'h8080_4210, 2'd2, 0);
    chk("R4 merged word", r_data, 32'hDEAD_77EF);

    access(1'b1, 1'b1, 32'h0CF8, 2'd2, 32'h8005_1A10);
    access(1'b1, 1'b0, 32'h0CFC, 2'd2, 0);
    chk("R6 bus field", 32'(cap_addr), 32'h051A10);

    // R7 disabled data port
    access(1'b1, 1'b1, 32'h0CF8, 2'd2, 32'h0000_1A10);
    access(1'b1, 1'b1, 32'h0CFC, 2'd2, 32'h1111_1111);
    chk("R7 disabled write no req", 32'(r_nreq), 32'd0);
    chk("R7 disabled write latency", 32'(r_cyc), 32'd1);
    access(1'b1, 1'b0, 32'h0CFD, 2'd0, 0);
    chk("R7 disabled read no req", 32'(r_nreq), 32'd0);
    chk("R7 disabled read ones", r_data, 32'h0000_00FF);
    access(1'b1, 1'b1, 32'h0CF8, 2'd2, 32'h8000_1A10);
    access(1'b1, 1'b0, 32'h0CFC, 2'd2, 0);
    chk("R7 disabled write had no effect", r_data, 32'hDEAD_77EF);

    // R8 timeout on silent device 7
    access(1'b0, 1'b0, 32'h8084_0000, 2'd2, 0);
    chk("R8 timeout req raised", 32'(r_nreq), 32'd1);
    chk("R8 timeout rdata", r_data, 32'hFFFF_FFFF);
    chk("R8 timeout latency", 32'(r_cyc), 32'(TMO + 1));
    access(1'b0, 1'b0, 32'h8084_0002, 2'd1, 0);
    chk("R8 timeout half rdata", r_data, 32'h0000_FFFF);
    access(1'b0, 1'b1, 32'h8084_0000, 2'd2, 32'h5555_5555);
    chk("R8 timeout write latency", 32'(r_cyc), 32'(TMO + 1));
    access(1'b0, 1'b0, 32'h8080_4210, 2'd2, 0);
    chk("R8 recovery after timeout", r_data, 32'hDEAD_77EF);

    // R10 unmapped accesses
    access(1'b1, 1'b0, 32'h0CF4, 2'd2, 0);
    chk("R10 io miss no req", 32'(r_nreq), 32'd0);
    chk("R10 io miss rdata", r_data, 32'hFFFF_FFFF);
    access(1'b0, 1'b0, 32'h0000_0CF8, 2'd1, 0);
    chk("R10 mem at port address", r_data, 32'h0000_FFFF);
    chk("R10 mem at port address no req", 32'(r_nreq), 32'd0);

    // R11 reset in mid run clears index
    do_reset();
    chk("R11 cfg_req after second reset", 32'(cfg_req), 32'd0);
    access(1'b1, 1'b0, 32'h0CF8, 2'd2, 0);
    chk("R11 index cleared by reset", r_data, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule